// File: doc/BRIEF.md
# Stereo I2S Master Controller

This block is a two-channel I2S bus master controlled through a small set of 32-bit memory-mapped registers. One clock drives everything. A programmable divider turns that clock into the serial bit clock. A frame engine produces the word-select line, shifts transmit samples out most significant bit first, and collects incoming bits into receive words. An eight-entry FIFO in each direction holds samples between the bus and the serial side. Each FIFO data port moves exactly one 32-bit sample per bus access.

Software does four things through the registers:
- It sets the bit-clock divider and the channel word length in one clock register.
- It switches transmit and receive on and off independently.
- It clears either FIFO, or the whole block, with self-clearing reset bits.
- It watches and clears sticky error flags in a status word.

The frame engine has three states:
- `ST_IDLE`: the bit clock is parked low.
- `ST_LEFT`: word-select is low.
- `ST_RIGHT`: word-select is high.

The transitions are:
- `ST_IDLE` to `ST_LEFT` on the first falling bit-clock edge after either enable is set.
- `ST_LEFT` to `ST_RIGHT` on the falling edge that ends bit slot W-1.
- `ST_RIGHT` to `ST_LEFT` on the falling edge that ends slot 2W-1.
- Any state to `ST_IDLE` as soon as both enables are clear, or on a global reset.

Here W is the word-length field plus one.

Top module: `i2s_ctl_top`

## Requirements
- R1: After reset, the control register (offset 0x04) reads 0 and the clock register (offset 0x08) reads 0x001F0000. The clock register holds the divider in bits [7:0] and the word length minus one in bits [20:16], and reads back what was written. Control bit 0 enables transmit; control bit 1 enables receive.
- R2: While either enable is set, each half period of the bit clock lasts divider+1 clock cycles, so a full bit-clock period is 2*(divider+1) cycles.
- R3: A frame lasts 2W bit-clock periods. Word-select is low for the W periods of the left channel and high for the W periods of the right channel.
- R4: Serial data leaves most significant bit first. The first bit of a channel is sent in the bit period after the word-select change, and the channel's last bit is sent in the period in which word-select has already changed. Data and word-select change only on falling bit-clock edges.
- R5: Transmit samples are taken from the FIFO alternately for left and right, in write order. With W < 32, only the top W bits are sent. A received word is placed in the top W bits of the receive sample, with the lower bits zero. In loopback, the receive FIFO returns the transmitted samples in order.
- R6: If the transmit FIFO is empty when a channel starts and transmit is enabled, zeros are sent and the sticky underflow flag (status bit 0) is set.
- R7: If a received word completes while the receive FIFO holds 8 entries, the word is dropped and the sticky overflow flag (status bit 1) is set. The 8 stored entries are kept.
- R8: Status bit 2 is set while the transmit FIFO holds 8 entries. A write to the transmit port at offset 0x2C while it is full is dropped. Status bit 3 is set while the receive FIFO is empty, so the status register reads 0x8 after reset.
- R9: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 leaves it unchanged.
- R10: Writing the reset register (offset 0x00) acts as a pulse for each bit set in the written value. Bit 0 restores every register, FIFO and flag to its reset value. Bit 1 empties the transmit FIFO. Bit 2 empties the receive FIFO.
- R11: A read of the receive port at offset 0x28 while the receive FIFO is empty returns 0 and changes nothing.
- R12: With receive disabled, nothing enters the receive FIFO. With transmit disabled, serial data stays low. With both disabled, the bit clock and word-select stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for bus and serial logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive port) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| i2s_bclk | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word-select, low for the left channel |
| i2s_sdo | output | 1 | Serial transmit data |
| i2s_sdi | input | 1 | Serial receive data |

## Verification
In the main pattern the serial output is looped back to the input. A bench monitor decodes the line from word-select and the bit clock, so a bit-order or alignment fault shows up at the pins even when transmit and receive happen to agree with each other. Random samples are run with random dividers and random word lengths of 8, 16, 24 and 32 bits. This separates the divider arithmetic, the frame-length arithmetic and the masking of short words, which a single fixed setting would blur together. Directed runs cover these cases:
- an empty transmit FIFO, which must give zeros and the underflow flag;
- a receive-only run fed with random serial bits, which must fill the FIFO to exactly eight entries and then flag overflow;
- a ninth write to a full transmit FIFO, which must never reach the line;
- reading an empty receive FIFO;
- each reset-register bit.

// File: rtl/i2s_ctl_pkg.sv
package i2s_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } frame_st_t;

    localparam int OFS_RESET = 8'h00;
    localparam int OFS_CTRL  = 8'h04;
    localparam int OFS_CLK   = 8'h08;
    localparam int OFS_STAT  = 8'h10;
    localparam int OFS_RXD   = 8'h28;
    localparam int OFS_TXD   = 8'h2C;

    localparam int WSIZE_LSB = 16;

endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bclk,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap     = run && !clr && (cnt == div);
    assign rise_stb = wrap && !bclk;
    assign fall_stb = wrap && bclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (clr || !run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (cnt == div) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_stb && !fall_stb && run && !clr) |=> $stable(bclk)); // R2

    AST_BCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bclk); // R12

endmodule

// File: rtl/i2s_sfifo.sv
module i2s_sfifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R8

    AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> empty); // R11

endmodule

// File: rtl/i2s_frame_engine.sv
module i2s_frame_engine
    import i2s_ctl_pkg::*;
#(
    parameter int DW   = 32,
    parameter int WS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic            tx_en,
    input  logic            rx_en,
    input  logic [WS_W-1:0] word_m1,
    input  logic            rise_stb,
    input  logic            fall_stb,
    input  logic [DW-1:0]   tx_head,
    input  logic            tx_empty,
    input  logic            rx_full,
    input  logic            sdin,
    output logic            tx_pop,
    output logic            uf_evt,
    output logic            rx_push,
    output logic            ov_evt,
    output logic [DW-1:0]   rx_word,
    output logic            ws,
    output logic            sdout
);

    localparam int SW = WS_W + 2;

    frame_st_t     st, st_nxt;
    logic [SW-1:0] slot, slot_nxt, wlen, last_slot;
    logic [SW-1:0] rx_cnt, rx_cnt_nxt;
    logic [DW-1:0] tx_sh, rx_sh, tx_load, rx_full_word;
    logic          live, load_slot, rx_start, rx_capture, rx_done;

    assign live      = run && !clr;
    assign wlen      = SW'(word_m1) + 1'b1;
    assign last_slot = (wlen << 1) - 1'b1;

    // next state and slot
    always_comb begin
        st_nxt   = st;
        slot_nxt = slot;
        unique case (st)
            ST_IDLE: begin
                if (live && fall_stb) begin
                    st_nxt   = ST_LEFT;
                    slot_nxt = '0;
                end
            end
            ST_LEFT: begin
                if (!live) begin
                    st_nxt   = ST_IDLE;
                    slot_nxt = '0;
                end else if (fall_stb) begin
                    slot_nxt = slot + 1'b1;
                    if (slot == wlen - 1'b1) st_nxt = ST_RIGHT;
                end
            end
            ST_RIGHT: begin
                if (!live) begin
                    st_nxt   = ST_IDLE;
                    slot_nxt = '0;
                end else if (fall_stb) begin
                    if (slot == last_slot) begin
                        st_nxt   = ST_LEFT;
                        slot_nxt = '0;
                    end else begin
                        slot_nxt = slot + 1'b1;
                    end
                end
            end
            default: begin
                st_nxt   = ST_IDLE;
                slot_nxt = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            slot <= '0;
        end else begin
            st   <= st_nxt;
            slot <= slot_nxt;
        end
    end

    assign ws = (st == ST_RIGHT);

    assign load_slot = fall_stb && (st_nxt != ST_IDLE) &&
                       ((slot_nxt == SW'(1)) || (slot_nxt == wlen + 1'b1));
    assign tx_pop    = load_slot && tx_en && !tx_empty;
    assign uf_evt    = load_slot && tx_en && tx_empty;
    assign tx_load   = tx_empty ? '0 : tx_head;

    assign rx_start     = (slot == SW'(1)) || (slot == wlen + 1'b1);
    assign rx_cnt_nxt   = rx_start ? SW'(1) : ((rx_cnt != '0) ? rx_cnt + 1'b1 : '0);
    assign rx_capture   = rise_stb && (st != ST_IDLE) && rx_en;
    assign rx_done      = rx_capture && (rx_cnt_nxt == wlen);
    assign rx_push      = rx_done && !rx_full;
    assign ov_evt       = rx_done && rx_full;
    assign rx_full_word = {rx_sh[DW-2:0], sdin};
    assign rx_word      = rx_full_word << (SW'(DW) - wlen);

    // outputs and shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            sdout  <= 1'b0;
            rx_sh  <= '0;
            rx_cnt <= '0;
        end else if (st_nxt == ST_IDLE) begin
            tx_sh  <= '0;
            sdout  <= 1'b0;
            rx_sh  <= '0;
            rx_cnt <= '0;
        end else begin
            if (fall_stb) begin
                if (!tx_en) begin
                    sdout <= 1'b0;
                    tx_sh <= '0;
                end else if (load_slot) begin
                    sdout <= tx_load[DW-1];
                    tx_sh <= tx_load << 1;
                end else begin
                    sdout <= tx_sh[DW-1];
                    tx_sh <= tx_sh << 1;
                end
            end
            if (rx_capture) begin
                rx_sh  <= rx_full_word;
                rx_cnt <= rx_done ? '0 : rx_cnt_nxt;
            end else if (!rx_en) begin
                rx_cnt <= '0;
            end
        end
    end

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !fall_stb) |=> $stable(ws)); // R4

    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !fall_stb) |=> $stable(sdout)); // R4

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= last_slot || st == ST_IDLE || $past(word_m1) != word_m1); // R3

endmodule

// File: rtl/i2s_ctl_top.sv
module i2s_ctl_top
    import i2s_ctl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DIV_W      = 8,
    parameter int WS_W       = 5,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              i2s_bclk,
    output logic              i2s_ws,
    output logic              i2s_sdo,
    input  logic              i2s_sdi
);

    localparam int DW = 32;

    logic             tx_en_q, rx_en_q, uf_q, ov_q;
    logic [DIV_W-1:0] div_q;
    logic [WS_W-1:0]  wsz_q;
    logic             wr_rst, wr_ctrl, wr_clk, wr_stat, tx_push, rx_pop;
    logic             glob_clr, tx_clr, rx_clr, run;
    logic             rise_stb, fall_stb;
    logic             tx_pop, uf_evt, rx_push, ov_evt;
    logic [DW-1:0]    tx_head, rx_head, rx_word;
    logic             tx_full, tx_empty, rx_full, rx_empty;

    assign wr_rst   = bus_wr && (bus_addr == ADDR_W'(OFS_RESET));
    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_clk   = bus_wr && (bus_addr == ADDR_W'(OFS_CLK));
    assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign tx_push  = bus_wr && (bus_addr == ADDR_W'(OFS_TXD));
    assign rx_pop   = bus_rd && (bus_addr == ADDR_W'(OFS_RXD));
    assign glob_clr = wr_rst && bus_wdata[0];
    assign tx_clr   = glob_clr || (wr_rst && bus_wdata[1]);
    assign rx_clr   = glob_clr || (wr_rst && bus_wdata[2]);
    assign run      = tx_en_q || rx_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
            div_q   <= '0;
            wsz_q   <= '1;
            uf_q    <= 1'b0;
            ov_q    <= 1'b0;
        end else if (glob_clr) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
            div_q   <= '0;
            wsz_q   <= '1;
            uf_q    <= 1'b0;
            ov_q    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                tx_en_q <= bus_wdata[0];
                rx_en_q <= bus_wdata[1];
            end
            if (wr_clk) begin
                div_q <= bus_wdata[DIV_W-1:0];
                wsz_q <= bus_wdata[WSIZE_LSB +: WS_W];
            end
            uf_q <= (uf_q && !(wr_stat && bus_wdata[0])) || uf_evt;
            ov_q <= (ov_q && !(wr_stat && bus_wdata[1])) || ov_evt;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[0] = tx_en_q;
            bus_rdata[1] = rx_en_q;
        end else if (bus_addr == ADDR_W'(OFS_CLK)) begin
            bus_rdata[DIV_W-1:0]          = div_q;
            bus_rdata[WSIZE_LSB +: WS_W]  = wsz_q;
        end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[3:0] = {rx_empty, tx_full, ov_q, uf_q};
        end else if (bus_addr == ADDR_W'(OFS_RXD)) begin
            if (!rx_empty) bus_rdata = rx_head;
        end
    end

    i2s_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst_n(rst_n), .clr(glob_clr), .run(run), .div(div_q),
        .bclk(i2s_bclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    i2s_sfifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .wdata(bus_wdata),
        .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty)
    );

    i2s_sfifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty)
    );

    i2s_frame_engine #(.DW(DW), .WS_W(WS_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .clr(glob_clr), .run(run),
        .tx_en(tx_en_q), .rx_en(rx_en_q), .word_m1(wsz_q),
        .rise_stb(rise_stb), .fall_stb(fall_stb),
        .tx_head(tx_head), .tx_empty(tx_empty), .rx_full(rx_full), .sdin(i2s_sdi),
        .tx_pop(tx_pop), .uf_evt(uf_evt), .rx_push(rx_push), .ov_evt(ov_evt),
        .rx_word(rx_word), .ws(i2s_ws), .sdout(i2s_sdo)
    );

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_q && !(wr_stat && bus_wdata[0]) && !glob_clr) |=> uf_q); // R6

    AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_q && !(wr_stat && bus_wdata[1]) && !glob_clr) |=> ov_q); // R7

    AST_RD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |-> (bus_rdata == '0)); // R11

    AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push && !tx_pop && !tx_clr) |=> tx_full); // R8

    AST_RX_OFF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_q |-> !rx_push); // R12

endmodule

// File: tb/test_i2s_ctl_top.sv
module test_i2s_ctl_top;

    localparam logic [7:0] A_RST  = 8'h00;
    localparam logic [7:0] A_CTRL = 8'h04;
    localparam logic [7:0] A_CLK  = 8'h08;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_RXD  = 8'h28;
    localparam logic [7:0] A_TXD  = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        i2s_bclk, i2s_ws, i2s_sdo, i2s_sdi;
    logic        loop_en = 1'b1;
    logic        drv_bit = 1'b0;

    assign i2s_sdi = loop_en ? i2s_sdo : drv_bit;

    always #10 clk = ~clk;

    i2s_ctl_top i_i2s_ctl_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws), .i2s_sdo(i2s_sdo), .i2s_sdi(i2s_sdi)
    );

    int n_chk = 0;
    int n_fail = 0;

    // serial line monitor: decodes words from ws and bclk
    logic [31:0] mon_acc;
    logic [31:0] mon_word [64];
    bit          mon_ch [64];
    int          mon_n;
    bit          mon_prev;

    always @(posedge i2s_bclk) begin
        mon_acc = {mon_acc[30:0], i2s_sdo};
        if (i2s_ws != mon_prev) begin
            if (mon_n < 64) begin
                mon_word[mon_n] = mon_acc;
                mon_ch[mon_n]   = mon_prev;
                mon_n++;
            end
            mon_prev = i2s_ws;
        end
    end

    task automatic mon_reset();
        mon_n    = 0;
        mon_acc  = '0;
        mon_prev = i2s_ws;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic measure(input bit use_ws, output int per);
        bit started = 0;
        int c = 0;
        logic p = use_ws ? i2s_ws : i2s_bclk;
        logic n;
        per = -1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            c++;
            n = use_ws ? i2s_ws : i2s_bclk;
            if (n && !p) begin
                if (started) begin
                    per = c;
                    break;
                end
                started = 1;
                c = 0;
            end
            p = n;
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] s, input int w);
        logic [31:0] m;
        m = (w >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> w);
        return s & m;
    endfunction

    function automatic logic [31:0] low_bits(input logic [31:0] v, input int w);
        return (w >= 32) ? v : (v & ((32'd1 << w) - 1));
    endfunction

    logic [31:0] smp [9];
    logic [31:0] r;
    int          per;

    initial begin
        #(64'd20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        mon_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset values
        rd(A_CTRL, r); chk("R1 ctrl reset", r, 32'h0);
        rd(A_CLK, r);  chk("R1 clk reset", r, 32'h001F_0000);
        rd(A_STAT, r); chk("R8 status reset", r, 32'h8);

        // divider 1, transmit only with empty FIFO
        wr(A_CLK, 32'h001F_0001);
        rd(A_CLK, r); chk("R1 clk readback", r, 32'h001F_0001);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, r); chk("R1 ctrl readback", r, 32'h1);
        measure(0, per); chk("R2 bclk period div1", per, 4);
        measure(1, per); chk("R3 ws period W32 div1", per, 256);
        begin
            logic seen = 1'b0;
            repeat (100) begin @(negedge clk); seen |= i2s_sdo; end
            chk("R6 zeros on underflow", seen, 1'b0);
        end
        rd(A_STAT, r); chk("R6 underflow flag, R12 rx idle empty", r, 32'h9);
        wr(A_CTRL, 32'h0);
        repeat (6) @(negedge clk);
        chk("R12 bclk parked", i2s_bclk, 1'b0);
        chk("R12 ws parked", i2s_ws, 1'b0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, r); chk("R9 write 0 keeps flag", r, 32'h9);
        wr(A_STAT, 32'h1);
        rd(A_STAT, r); chk("R9 write 1 clears flag", r, 32'h8);

        // divider 2, receive only, random serial input -> overflow
        wr(A_CLK, 32'h001F_0002);
        loop_en = 1'b0;
        wr(A_CTRL, 32'h2);
        measure(0, per); chk("R2 bclk period div2", per, 6);
        wr(A_CTRL, 32'h0);
        wr(A_RST, 32'h4);
        wr(A_CLK, 32'h001F_0000);
        wr(A_CTRL, 32'h2);
        begin
            logic seen = 1'b0;
            repeat (1400) begin
                @(negedge clk);
                drv_bit = 1'($urandom);
                seen |= i2s_sdo;
            end
            chk("R12 sdo low with tx off", seen, 1'b0);
        end
        wr(A_CTRL, 32'h0);
        rd(A_STAT, r); chk("R7 overflow flag", r, 32'h2);
        for (int i = 0; i < 7; i++) rd(A_RXD, r);
        rd(A_STAT, r); chk("R7 seven read, not empty", r[3], 1'b0);
        rd(A_RXD, r);
        rd(A_STAT, r); chk("R7 eight entries kept", r[3], 1'b1);
        rd(A_RXD, r); chk("R11 empty read zero", r, 32'h0);
        rd(A_STAT, r); chk("R11 empty read inert", r, 32'hA);
        wr(A_STAT, 32'h3);

        // loopback, 32-bit words, full transmit FIFO and a dropped ninth write
        loop_en = 1'b1;
        wr(A_RST, 32'h6);
        for (int i = 0; i < 9; i++) begin
            smp[i] = $urandom;
            if (i == 8) begin
                rd(A_STAT, r); chk("R8 tx full flag", r[2], 1'b1);
            end
            wr(A_TXD, smp[i]);
        end
        mon_reset();
        wr(A_CTRL, 32'h3);
        repeat (700) @(negedge clk);
        wr(A_CTRL, 32'h0);
        chk("R4 monitor word count", (mon_n >= 9), 1'b1);
        for (int i = 0; i < 8; i++) begin
            chk("R4 msb-first line word", mon_word[i], smp[i]);
            chk("R3 ws low for left", 32'(mon_ch[i]), 32'(i % 2));
        end
        chk("R8 ninth write dropped, R6 zeros", mon_word[8], 32'h0);
        rd(A_STAT, r); chk("R6 R7 flags after loopback", r, 32'h3);
        for (int i = 0; i < 8; i++) begin
            rd(A_RXD, r); chk("R5 loopback order", r, smp[i]);
        end
        rd(A_RXD, r); chk("R11 empty read zero after drain", r, 32'h0);

        // random divider and word length
        for (int k = 0; k < 4; k++) begin
            int dv = int'($urandom % 4);
            int wm1 = 7 + 8 * int'($urandom % 4);
            int w = wm1 + 1;
            wr(A_RST, 32'h6);
            wr(A_STAT, 32'h3);
            wr(A_CLK, (32'(wm1) << 16) | 32'(dv));
            for (int i = 0; i < 4; i++) begin
                smp[i] = $urandom;
                wr(A_TXD, smp[i]);
            end
            mon_reset();
            wr(A_CTRL, 32'h3);
            measure(0, per); chk("R2 bclk period random", per, 2 * (dv + 1));
            measure(1, per); chk("R3 ws period random", per, 4 * w * (dv + 1));
            repeat (4 * w * (dv + 1) * 3) @(negedge clk);
            wr(A_CTRL, 32'h0);
            for (int i = 0; i < 4; i++) begin
                chk("R4 line word random", low_bits(mon_word[i], w), smp[i] >> (32 - w));
                rd(A_RXD, r); chk("R5 received top bits", r, exp_word(smp[i], w));
            end
        end

        // FIFO clears and global reset
        wr(A_RST, 32'h6);
        wr(A_STAT, 32'h3);
        for (int i = 0; i < 8; i++) wr(A_TXD, 32'(i));
        rd(A_STAT, r); chk("R8 full before clear", r[2], 1'b1);
        wr(A_RST, 32'h2);
        rd(A_STAT, r); chk("R10 tx clear", r[2], 1'b0);
        wr(A_CLK, 32'h001F_0000);
        wr(A_TXD, 32'h1234_5678);
        wr(A_TXD, 32'h9ABC_DEF0);
        wr(A_CTRL, 32'h3);
        repeat (300) @(negedge clk);
        wr(A_CTRL, 32'h0);
        rd(A_STAT, r); chk("R10 rx has data", r[3], 1'b0);
        wr(A_RST, 32'h4);
        rd(A_STAT, r); chk("R10 rx clear", r[3], 1'b1);
        wr(A_CLK, 32'h0005_0007);
        wr(A_CTRL, 32'h3);
        wr(A_RST, 32'h1);
        rd(A_CTRL, r); chk("R10 global ctrl", r, 32'h0);
        rd(A_CLK, r);  chk("R10 global clk", r, 32'h001F_0000);
        rd(A_STAT, r); chk("R10 global status", r, 32'h8);
        repeat (4) @(negedge clk);
        chk("R12 bclk low after global", i2s_bclk, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule